// File: doc/BRIEF.md
# Lane Synchronization State Machine

This block decides whether an 8b/10b receive lane is synchronized. An upstream word aligner and decoder hand it one code-group event per clock. Each event carries a valid strobe, a flag saying the group was a valid K28.5 comma, and a flag saying the group was erroneous (disparity or code violation). The single output, `sync_ok`, is high for as long as the lane counts as synchronized. Downstream logic, such as a rate-match FIFO, waits for it before starting work.

The machine has three states:
- `ST_LOST` is the reset and loss-of-sync state.
- `ST_ACQUIRE` is entered on the first valid comma and counts further commas.
- `ST_SYNCED` holds `sync_ok` high.

Its transitions are:
- LOST→ACQUIRE on a clean comma.
- ACQUIRE→SYNCED on the fourth clean comma.
- ACQUIRE→LOST on any erroneous group.
- SYNCED→LOST when the accumulated error count reaches 17.

While synchronized, each erroneous group adds one to the error count and clears the good-run counter. Every run of 16 consecutive good groups takes one away from the error count, which never drops below zero. The alignment patterns are 10-bit code groups, so one event corresponds to one 10-bit symbol.

Top module: `lane_sync_fsm`

## Requirements
- R1: After reset, and before any comma is seen, `sync_ok` is low and the machine is in `ST_LOST` with every counter cleared.
- R2: `sync_ok` rises on the clock edge that samples the fourth clean comma (`cg_valid`=1, `cg_comma`=1, `cg_error`=0) of an acquisition attempt. Good non-comma groups in between neither count nor reset the tally.
- R3: During acquisition, any group with `cg_error`=1 returns the machine to `ST_LOST` and sets the comma tally to zero, so four further clean commas are needed.
- R4: A cycle with `cg_valid`=0 has no effect, whatever `cg_comma` and `cg_error` carry.
- R5: Once synchronized, `sync_ok` stays high while fewer than 17 errors are accumulated.
- R6: On the edge that samples the 17th accumulated error, `sync_ok` falls and both the error count and the comma tally clear. Re-synchronizing takes four fresh commas.
- R7: Each run of 16 consecutive good groups while synchronized lowers the error count by one. An erroneous group restarts the run from zero.
- R8: The error count saturates at zero: good runs while the count is zero bank no credit. It also never exceeds its loss threshold.
- R9: A group flagged as both comma and error counts as an error, not as a comma.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, one code group per cycle |
| rst_n | input | 1 | Active-low synchronous reset |
| cg_valid | input | 1 | A code group is presented this cycle |
| cg_comma | input | 1 | The group is a valid K28.5 comma |
| cg_error | input | 1 | The group is erroneous |
| sync_ok | output | 1 | High while the lane is synchronized |

## Verification
A wrong comma tally appears at `sync_ok` as a rise one group early or late relative to the fourth clean comma, visible on the very next cycle. A wrong error count or good-run counter stays hidden until a loss event. It shows as `sync_ok` falling on an error other than the one the requirement predicts, so the tests build exact error histories (runs of 15 and 16 good groups, runs while the count is zero) and then probe the single group where loss must or must not occur.

// File: rtl/lane_sync_pkg.sv
package lane_sync_pkg;
    typedef enum logic [1:0] {
        ST_LOST    = 2'd0,
        ST_ACQUIRE = 2'd1,
        ST_SYNCED  = 2'd2
    } sync_state_t;
endpackage

// File: rtl/lane_comma_tally.sv
module lane_comma_tally #(
    parameter int NEED = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic inc,
    output logic done
);
    localparam int W = $clog2(NEED + 1);
    localparam logic [W-1:0] LAST = W'(NEED - 1);

    logic [W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            cnt_q <= '0;
        end else if (inc) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    always_comb done = inc && (cnt_q == LAST);

    AST_TALLY_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q < W'(NEED)); // R2
    AST_TALLY_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> cnt_q == '0); // R3
endmodule

// File: rtl/lane_err_tracker.sv
module lane_err_tracker #(
    parameter int LOSS_ERRS = 17,
    parameter int GOOD_RUN  = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic en,
    input  logic bad,
    output logic loss_hit
);
    localparam int EW = $clog2(LOSS_ERRS + 1);
    localparam int RW = (GOOD_RUN > 1) ? $clog2(GOOD_RUN) : 1;
    localparam logic [EW-1:0] ERR_LAST = EW'(LOSS_ERRS - 1);
    localparam logic [EW-1:0] ERR_MAX  = EW'(LOSS_ERRS);
    localparam logic [RW-1:0] RUN_LAST = RW'(GOOD_RUN - 1);

    logic [EW-1:0] err_q;
    logic [RW-1:0] run_q;

    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            err_q <= '0;
            run_q <= '0;
        end else if (en) begin
            if (bad) begin
                run_q <= '0;
                if (err_q != ERR_MAX) err_q <= err_q + 1'b1;
            end else if (run_q == RUN_LAST) begin
                run_q <= '0;
                if (err_q != '0) err_q <= err_q - 1'b1;
            end else begin
                run_q <= run_q + 1'b1;
            end
        end
    end

    always_comb loss_hit = en && bad && (err_q == ERR_LAST);

    AST_ERR_CEILING: assert property (@(posedge clk) disable iff (!rst_n)
        err_q <= ERR_MAX); // R8
    AST_GOOD_NO_RISE: assert property (@(posedge clk) disable iff (!rst_n)
        (en && !bad && !clr) |=> err_q <= $past(err_q)); // R7
    AST_BAD_RESTARTS_RUN: assert property (@(posedge clk) disable iff (!rst_n)
        (en && bad) |=> run_q == '0); // R7
endmodule

// File: rtl/lane_sync_fsm.sv
module lane_sync_fsm
    import lane_sync_pkg::*;
#(
    parameter int ACQ_COMMAS = 4,
    parameter int LOSS_ERRS  = 17,
    parameter int GOOD_RUN   = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cg_valid,
    input  logic cg_comma,
    input  logic cg_error,
    output logic sync_ok
);
    sync_state_t state_q, state_d;
    logic clean_comma, bad_cg, hunting;
    logic tally_inc, tally_clr, tally_done;
    logic trk_en, trk_clr, loss_hit;

    always_comb begin
        clean_comma = cg_valid && cg_comma && !cg_error;
        bad_cg      = cg_valid && cg_error;
        hunting     = (state_q != ST_SYNCED);
        tally_inc   = hunting && clean_comma;
        tally_clr   = (hunting && bad_cg) || tally_done || (state_q == ST_SYNCED);
        trk_en      = (state_q == ST_SYNCED) && cg_valid;
        trk_clr     = hunting || loss_hit;
    end

    lane_comma_tally #(.NEED(ACQ_COMMAS)) i_tally (
        .clk  (clk),
        .rst_n(rst_n),
        .clr  (tally_clr),
        .inc  (tally_inc),
        .done (tally_done)
    );

    lane_err_tracker #(.LOSS_ERRS(LOSS_ERRS), .GOOD_RUN(GOOD_RUN)) i_errs (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (trk_clr),
        .en      (trk_en),
        .bad     (cg_error),
        .loss_hit(loss_hit)
    );

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_LOST: begin
                if (tally_done)     state_d = ST_SYNCED;
                else if (tally_inc) state_d = ST_ACQUIRE;
            end
            ST_ACQUIRE: begin
                if (bad_cg)          state_d = ST_LOST;
                else if (tally_done) state_d = ST_SYNCED;
            end
            ST_SYNCED: begin
                if (loss_hit) state_d = ST_LOST;
            end
            default: state_d = ST_LOST;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_LOST;
        else        state_q <= state_d;
    end

    always_comb sync_ok = (state_q == ST_SYNCED);

    AST_RISE_ON_COMMA: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sync_ok) |-> $past(clean_comma)); // R2
    AST_FALL_ON_ERROR: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(sync_ok) |-> $past(bad_cg)); // R6
    AST_ACQ_ERR_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_ACQUIRE && bad_cg) |=> state_q == ST_LOST); // R3
    AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        !cg_valid |=> $stable(state_q)); // R4
endmodule

// File: tb/test_lane_sync_fsm.sv
module test_lane_sync_fsm;
    localparam int CLK_PERIOD = 10;
    localparam int NVEC = 16;
    // each entry: {valid, comma, error, expected sync_ok after the edge}
    localparam logic [3:0] VEC [NVEC] = '{
        4'b1100, 4'b1100, 4'b1010, 4'b1100,
        4'b0110, 4'b1100, 4'b1000, 4'b1100,
        4'b1110, 4'b1100, 4'b1100, 4'b1100,
        4'b1101, 4'b1011, 4'b0011, 4'b1101
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cg_valid = 1'b0, cg_comma = 1'b0, cg_error = 1'b0;
    logic sync_ok;
    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    lane_sync_fsm i_lane_sync_fsm (
        .clk(clk), .rst_n(rst_n), .cg_valid(cg_valid),
        .cg_comma(cg_comma), .cg_error(cg_error), .sync_ok(sync_ok)
    );

    task automatic put(input logic v, input logic c, input logic e);
        @(negedge clk);
        cg_valid = v; cg_comma = c; cg_error = e;
        @(posedge clk);
        #1;
    endtask

    task automatic expect_sync(input logic exp, input string req);
        checks++;
        if (sync_ok !== exp) begin
            errors++;
            $display("FAIL %s: sync_ok=%b expected %b", req, sync_ok, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; cg_valid = 1'b0; cg_comma = 1'b0; cg_error = 1'b0;
        @(posedge clk); @(posedge clk);
        #1;
        expect_sync(1'b0, "R1");
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic acquire();
        for (int k = 0; k < 4; k++) put(1'b1, 1'b1, 1'b0);
    endtask

    task automatic errs(input int n);
        for (int k = 0; k < n; k++) put(1'b1, 1'b0, 1'b1);
    endtask

    task automatic goods(input int n);
        for (int k = 0; k < n; k++) put(1'b1, 1'b0, 1'b0);
    endtask

    initial begin
        do_reset();
        // table: R2 acquisition, R3 error restart, R4 idle, R9 comma+error, R5
        for (int i = 0; i < NVEC; i++) begin
            put(VEC[i][3], VEC[i][2], VEC[i][1]);
            expect_sync(VEC[i][0], "R2/R3/R4/R5/R9 vector");
        end

        // R6: 16 errors keep sync, the 17th drops it, re-acquire needs 4 fresh
        do_reset();
        acquire();
        expect_sync(1'b1, "R2");
        errs(16);
        expect_sync(1'b1, "R5");
        errs(1);
        expect_sync(1'b0, "R6");
        for (int k = 0; k < 3; k++) put(1'b1, 1'b1, 1'b0);
        expect_sync(1'b0, "R6");
        put(1'b1, 1'b1, 1'b0);
        expect_sync(1'b1, "R6");

        // R7: a run of 16 good groups earns back one error
        do_reset();
        acquire();
        errs(16);
        goods(16);
        errs(1);
        expect_sync(1'b1, "R7");
        errs(1);
        expect_sync(1'b0, "R7");

        // R7: an error restarts the good run
        do_reset();
        acquire();
        errs(15);
        goods(15);
        errs(1);
        goods(15);
        errs(1);
        expect_sync(1'b0, "R7");

        // R8: good runs at zero errors bank nothing
        do_reset();
        acquire();
        goods(48);
        errs(16);
        expect_sync(1'b1, "R8");
        errs(1);
        expect_sync(1'b0, "R8");

        // R4: idle cycles with flags set do not disturb a synced lane
        do_reset();
        acquire();
        for (int k = 0; k < 20; k++) put(1'b0, 1'b0, 1'b1);
        expect_sync(1'b1, "R4");

        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (20000) @(posedge clk);
                checks++;
                errors++;
                $display("FAIL watchdog: done=0 expected 1");
            end
        join_any
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule